// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic core of a small 8-bit processor datapath. It takes the accumulator value and a second operand and, for the operation code on its control pins, forms an 8-bit result with five condition flags: sign, zero, nibble (auxiliary) carry, even parity and carry. Addition, subtraction, compare, increment and decrement all share one adder split at the nibble boundary. Subtraction adds the inverted operand, and the carry flag then stands for a borrow.

The result and a write-back strobe are combinational. The strobe tells the surrounding datapath whether the result should be written to its destination. That destination is the accumulator for most operations and the register supplied on the operand port for increment and decrement. The flags are held in a five-bit register inside the block. That register loads on a clock edge when the flag-write enable is high. The held carry feeds back as the carry-in for add-with-carry and as the borrow-in for subtract-with-borrow.

All pins are plain control and data pins. The datapath is combinational, so there is no valid/ready flow and no back-pressure.

Top module: `alu8_flags`

## Requirements
- R1: Op code 0 (add) gives res_o = acc_i + opnd_i mod 256 and op code 1 (add with carry) also adds the held carry flag. The next carry flag is the carry out of bit 7. The nibble carry is the carry out of bit 3 into bit 4.
- R2: Op codes 2 (subtract), 3 (subtract with borrow, which also subtracts the held carry) and 7 (compare) give acc_i - opnd_i mod 256. The carry flag is set exactly when a borrow is needed. The nibble carry is the carry out of bit 3 of acc_i + ~opnd_i + (1 - borrow_in).
- R3: Op codes 4, 5 and 6 give the bitwise AND, OR and XOR of acc_i and opnd_i, and they clear both the carry and the nibble carry flags.
- R4: Op code 8 gives opnd_i + 1 and op code 9 gives opnd_i - 1, both mod 256. The nibble carry is set for increment when opnd_i[3:0] is 15, and for decrement when opnd_i[3:0] is not 0. The carry flag keeps its previous value.
- R5: flags_o is {sign, zero, nibble carry, parity, carry} from bit 4 down to bit 0. After a flag write, sign equals bit 7 of the result, zero is set exactly when the result is 0, and parity is set exactly when the result has an even number of ones.
- R6: wb_en_o is high for op codes 0 to 6, 8 and 9, and low for compare (op code 7).
- R7: flags_o loads the new flags only on a rising clock edge with flag_we_i high. Otherwise it holds its value.
- R8: When rst_n is low, flags_o is cleared to 0.
- R9: Op codes 10 to 15 are undefined. For these, res_o equals acc_i, wb_en_o is low, and flags_o is unchanged even with flag_we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand; the target register for increment and decrement |
| flag_we_i | input | 1 | Flag register write enable |
| res_o | output | 8 | Combinational result |
| wb_en_o | output | 1 | Result should be written to its destination |
| flags_o | output | 5 | Held flags {S, Z, AC, P, CY} |

## Verification
The hardest corner to reach is the interaction between the held carry and the chained operations. Add-with-carry and subtract-with-borrow must be exercised with both values of the held carry, yet that value can only be set by an earlier flag-writing operation. Before each vector, the stimulus therefore forces the carry with an add of 0xFF + 0x01 or of 0x00 + 0x00. The operand sweep includes 0x00, 0xFF and nibble-boundary values, so borrow chains and the bit-3 carry are hit in both directions.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  localparam int FLG_CY = 0;
  localparam int FLG_P  = 1;
  localparam int FLG_AC = 2;
  localparam int FLG_Z  = 3;
  localparam int FLG_S  = 4;
  localparam int FLG_W  = 5;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_nib,
  output logic         c_out
);
  localparam int HW = W - NIB;

  logic [NIB:0] lo;
  logic [HW:0]  hi;

  assign lo    = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign hi    = {1'b0, a[W-1:NIB]} + {1'b0, b[W-1:NIB]} + {{HW{1'b0}}, lo[NIB]};
  assign sum   = {hi[HW-1:0], lo[NIB-1:0]};
  assign c_nib = lo[NIB];
  assign c_out = hi[HW];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (sel)
        2'd0:    y[i] = a[i] & b[i];
        2'd1:    y[i] = a[i] | b[i];
        default: y[i] = a[i] ^ b[i];
      endcase
    end
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [FW-1:0] d,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NIB   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             flag_we_i,
  output logic [WIDTH-1:0] res_o,
  output logic             wb_en_o,
  output logic [FLG_W-1:0] flags_o
);
  logic [WIDTH-1:0] add_a, add_b, add_sum, lres;
  logic             add_cin, c_nib, c_out;
  logic [1:0]       lsel;
  logic             is_sub, is_logic, is_step, op_ok;
  logic             cy_q;
  logic [FLG_W-1:0] fl_next;

  assign cy_q = flags_o[FLG_CY];

  always_comb begin
    add_a    = acc_i;
    add_b    = opnd_i;
    add_cin  = 1'b0;
    lsel     = 2'd0;
    is_sub   = 1'b0;
    is_logic = 1'b0;
    is_step  = 1'b0;
    op_ok    = 1'b1;
    case (op_i)
      OP_ADD: ;
      OP_ADC: add_cin = cy_q;
      OP_SUB, OP_CMP: begin
        add_b   = ~opnd_i;
        add_cin = 1'b1;
        is_sub  = 1'b1;
      end
      OP_SBB: begin
        add_b   = ~opnd_i;
        add_cin = ~cy_q;
        is_sub  = 1'b1;
      end
      OP_AND: is_logic = 1'b1;
      OP_OR: begin
        is_logic = 1'b1;
        lsel     = 2'd1;
      end
      OP_XOR: begin
        is_logic = 1'b1;
        lsel     = 2'd2;
      end
      OP_INC: begin
        add_a   = opnd_i;
        add_b   = '0;
        add_cin = 1'b1;
        is_step = 1'b1;
      end
      OP_DEC: begin
        add_a   = opnd_i;
        add_b   = '1;
        is_step = 1'b1;
      end
      default: op_ok = 1'b0;
    endcase
  end

  alu8_adder #(.W(WIDTH), .NIB(NIB)) u_add (
    .a(add_a), .b(add_b), .cin(add_cin),
    .sum(add_sum), .c_nib(c_nib), .c_out(c_out)
  );

  alu8_logic #(.W(WIDTH)) u_log (
    .sel(lsel), .a(acc_i), .b(opnd_i), .y(lres)
  );

  assign res_o   = is_logic ? lres : (op_ok ? add_sum : acc_i);
  assign wb_en_o = op_ok && (op_i != OP_CMP);

  always_comb begin
    fl_next          = '0;
    fl_next[FLG_S]   = res_o[WIDTH-1];
    fl_next[FLG_Z]   = (res_o == '0);
    fl_next[FLG_P]   = ~^res_o;
    fl_next[FLG_AC]  = is_logic ? 1'b0 : c_nib;
    if (is_step)       fl_next[FLG_CY] = cy_q;
    else if (is_logic) fl_next[FLG_CY] = 1'b0;
    else               fl_next[FLG_CY] = is_sub ? ~c_out : c_out;
  end

  alu8_flagreg #(.FW(FLG_W)) u_freg (
    .clk(clk), .rst_n(rst_n), .we(flag_we_i && op_ok),
    .d(fl_next), .q(flags_o)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_i,
  input logic [7:0] acc_i,
  input logic       flag_we_i,
  input logic [7:0] res_o,
  input logic       wb_en_o,
  input logic [4:0] flags_o
);
  assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i <= 4'd9) |=> flags_o[4] == $past(res_o[7]));
  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i <= 4'd9) |=> flags_o[3] == ($past(res_o) == 8'd0));
  assert_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i <= 4'd9) |=> flags_o[1] == ($countones($past(res_o)) % 2 == 0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(flags_o));
  assert_step_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && (op_i == 4'd8 || op_i == 4'd9)) |=> flags_o[0] == $past(flags_o[0]));
  assert_logic_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_i && op_i >= 4'd4 && op_i <= 4'd6) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0));
  assert_cmp_nowb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7) |-> !wb_en_o);
  assert_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 4'd9) |-> (res_o == acc_i && !wb_en_o));
  assert_undef_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 4'd9) |=> $stable(flags_o));
  assert_reset_R8: assert property (@(posedge clk)
    !rst_n |=> flags_o == 5'd0);
endmodule

bind alu8_flags alu8_flags_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
  .flag_we_i(flag_we_i), .res_o(res_o), .wb_en_o(wb_en_o), .flags_o(flags_o)
);

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'd0, opnd = 8'd0;
  logic       we = 1'b0;
  logic [7:0] res;
  logic       wb;
  logic [4:0] flags;
  logic [4:0] exp_fl = 5'd0;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .flag_we_i(we), .res_o(res), .wb_en_o(wb), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Applies one vector, checks the combinational result, then the flags after the edge.
  task automatic run(input int o, input int a, input int b, input bit w, input string tag);
    int r, cy, ac, c, bor;
    bit valid;
    logic [7:0] rv;
    logic [4:0] nf;
    valid = 1;
    cy = exp_fl[0];
    ac = 0;
    r  = a;
    case (o)
      0, 1: begin
        c  = (o == 1) ? int'(exp_fl[0]) : 0;
        r  = a + b + c;
        cy = (r > 255);
        ac = (((a & 15) + (b & 15) + c) > 15);
      end
      2, 3, 7: begin
        bor = (o == 3) ? int'(exp_fl[0]) : 0;
        r   = a - b - bor;
        cy  = (a < b + bor);
        ac  = (((a & 15) + ((~b) & 15) + 1 - bor) > 15);
      end
      4: begin r = a & b; cy = 0; end
      5: begin r = a | b; cy = 0; end
      6: begin r = a ^ b; cy = 0; end
      8: begin r = b + 1; ac = ((b & 15) == 15); end
      9: begin r = b - 1; ac = ((b & 15) != 0); end
      default: valid = 0;
    endcase
    rv = r[7:0];
    @(negedge clk);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; we = w;
    #2;
    chk(res === rv, tag, "result", res, rv);
    chk(wb === (valid && o != 7), valid ? ((o == 7) ? "R6" : "R6") : "R9", "wb_en", wb,
        valid && o != 7);
    nf = {rv[7], rv == 8'd0, ac[0], ~^rv, cy[0]};
    @(posedge clk);
    #1;
    if (w && valid) exp_fl = nf;
    chk(flags === exp_fl, {tag, " R5"}, "flags", flags, exp_fl);
  endtask

  task automatic set_cy(input bit c);
    if (c) run(0, 255, 1, 1'b1, "R1");
    else   run(0, 0, 0, 1'b1, "R1");
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(flags === 5'd0, "R8", "reset flags", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 3) begin
        run(0, a, b, 1'b1, "R1");
        run(2, a, b, 1'b1, "R2");
        run(7, a, b, 1'b1, "R2");
        run(4, a, b, 1'b1, "R3");
        run(5, a, b, 1'b1, "R3");
        run(6, a, b, 1'b1, "R3");
      end

    for (int a = 0; a < 256; a += 15)
      for (int b = 0; b < 256; b += 7)
        for (int c = 0; c < 2; c++) begin
          set_cy(c[0]);
          run(1, a, b, 1'b1, "R1");
          set_cy(c[0]);
          run(3, a, b, 1'b1, "R2");
        end

    for (int b = 0; b < 256; b++)
      for (int c = 0; c < 2; c++) begin
        set_cy(c[0]);
        run(8, 0, b, 1'b1, "R4");
        set_cy(c[0]);
        run(9, 0, b, 1'b1, "R4");
      end

    // R7: flag-changing operations with the write enable low
    run(0, 255, 1, 1'b1, "R7");
    for (int o = 0; o < 10; o++) run(o, 18, 200, 1'b0, "R7");
    run(0, 0, 0, 1'b1, "R7");
    for (int o = 0; o < 10; o++) run(o, 129, 1, 1'b0, "R7");

    // R9: undefined codes with the write enable high
    run(2, 0, 1, 1'b1, "R9");
    for (int o = 10; o < 16; o++) run(o, 90 + o, 3, 1'b1, "R9");

    // R8: asynchronous clear from a non-zero flag state
    run(2, 0, 1, 1'b1, "R8");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_fl = 5'd0;
    chk(flags === 5'd0, "R8", "async clear", flags, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule